// File: doc/BRIEF.md
# Four-Bit Zero-Address Processor Core

This core executes programs for a machine with no general-purpose registers. Every operand sits on an eight-entry operand stack of 4-bit values. Arithmetic and logic take their inputs from the upper stack entries and leave the result there. Code, data and memory-mapped devices share one space of 4096 nibble locations, reached through a synchronous memory port with one cycle of read latency. Each instruction is one opcode nibble, followed by zero, one or three operand nibbles.

Subroutine linkage does not use the operand stack. A call writes its 12-bit return address, one nibble at a time, into a write-protected window at the top of the memory space. A return reads that address back. An ordinary store that targets the window is dropped. The core has no interrupts. On a stack fault, or when the return window is exhausted, it latches an error and stops.

Top module: `stack4_cpu`

## Requirements
- R1: While reset is held, and on leaving it, the stack is empty, `tos_o` is 0, `carry_o` and `err_o` are 0 and no memory write is issued. The first opcode is fetched from address 0x000.
- R2: Opcodes are 0 PUSH, 1 LOAD, 2 STORE, 3 JMP, 4 JZ, 5 CALL, 6 RET, 7 ADD, 8 SUB, 9 AND, A OR, B XOR, C NOT, D DUP, E DROP, F SWAP. PUSH has one immediate nibble. LOAD, STORE, JMP, JZ and CALL have a 12-bit address in three nibbles, least significant nibble at the lowest address. All other opcodes are a single nibble. LOAD pushes the addressed nibble.
- R3: ADD, SUB, AND, OR and XOR pop the top (b) and the entry below it (a), then push a op b (a minus b for SUB). ADD sets the carry when a+b exceeds 15. SUB sets it when a is less than b. No other instruction changes the carry.
- R4: NOT inverts the top entry in place. DUP pushes a copy of the top entry. DROP discards the top entry. SWAP exchanges the top two entries.
- R5: STORE writes the top entry to its address and pops it. When the address is 0xFE2 or above, no write is issued, but the pop still takes place.
- R6: JMP loads the program counter. JZ pops the top entry and branches only if that entry was zero; otherwise execution continues after the JZ.
- R7: CALL writes the address of the next instruction, least significant nibble first, to the next three free nibbles of the return window, starting at 0xFE2, then jumps. RET reads the most recent return address back and resumes there.
- R8: A push with eight entries on the stack, or an instruction that needs more entries than the stack holds, sets a sticky `err_o` and halts. The faulting instruction changes neither the stack nor memory.
- R9: An eleventh nested CALL (window full) and a RET with no open call also set `err_o` and halt.
- R10: Once `err_o` is set, no memory write is issued and the stack no longer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 12 | Memory nibble address, read every cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 4 | Memory write data |
| mem_rdata_i | input | 4 | Read data for the address of the previous cycle |
| tos_o | output | 4 | Top stack entry, 0 when empty |
| depth_o | output | 4 | Number of stack entries |
| carry_o | output | 1 | Carry/borrow flag |
| err_o | output | 1 | Sticky fault, core halted |

## Verification
The critical overlap is a STORE aimed at the return window. In a single execute cycle the core must pop the stack and suppress the memory write. Directed programs store just below and just inside the window. The bench then reads back both memory cells and the stack depth, expecting the pop to happen while only the in-window cell stays untouched. The same coincidence appears when a push meets a full stack. That case is provoked with nine pushes ahead of a store, and it passes only if the depth stays at eight and the store never lands.

// File: rtl/stack4_pkg.sv
package stack4_pkg;
  localparam int DW = 4;
  localparam int AW = 12;

  typedef enum logic [3:0] {
    OP_PUSH = 4'h0, OP_LOAD, OP_STORE, OP_JMP, OP_JZ, OP_CALL, OP_RET, OP_ADD,
    OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_DUP, OP_DROP, OP_SWAP
  } op_e;

  typedef enum logic [2:0] {SK_NONE, SK_PUSH, SK_POP, SK_BIN, SK_REPL, SK_SWAP} sk_op_e;

  // operand nibbles following the opcode
  function automatic logic [1:0] op_len(op_e op);
    case (op)
      OP_PUSH: return 2'd1;
      OP_LOAD, OP_STORE, OP_JMP, OP_JZ, OP_CALL: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/stack4_alu.sv
module stack4_alu import stack4_pkg::*; (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          c_o
);
  logic [DW:0] sum, dif;
  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    c_o = 1'b0;
    case (op_i)
      OP_ADD: {c_o, y_o} = sum;
      OP_SUB: {c_o, y_o} = dif;
      OP_AND: y_o = a_i & b_i;
      OP_OR:  y_o = a_i | b_i;
      OP_XOR: y_o = a_i ^ b_i;
      OP_NOT: y_o = ~b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/stack4_opstack.sv
module stack4_opstack import stack4_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sk_op_e        op_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] nos_o,
  output logic [CW-1:0] depth_o
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [CW-1:0] depth_q;
  logic [IW-1:0] top_i, nos_i, free_i;

  assign top_i  = IW'(depth_q - CW'(1));
  assign nos_i  = IW'(depth_q - CW'(2));
  assign free_i = IW'(depth_q);
  assign tos_o  = (depth_q != '0) ? ent_q[top_i] : '0;
  assign nos_o  = (depth_q > CW'(1)) ? ent_q[nos_i] : '0;
  assign depth_o = depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      case (op_i)
        SK_PUSH: begin ent_q[free_i] <= data_i; depth_q <= depth_q + CW'(1); end
        SK_POP:  depth_q <= depth_q - CW'(1);
        SK_BIN:  begin ent_q[nos_i] <= data_i; depth_q <= depth_q - CW'(1); end
        SK_REPL: ent_q[top_i] <= data_i;
        SK_SWAP: begin ent_q[top_i] <= ent_q[nos_i]; ent_q[nos_i] <= ent_q[top_i]; end
        default: ;
      endcase
    end
  end

  // R8
  depth_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= CW'(DEPTH));
  // R8
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SK_PUSH |-> depth_q < CW'(DEPTH));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SK_POP || op_i == SK_REPL) |-> depth_q != '0);
endmodule

// File: rtl/stack4_cpu.sv
module stack4_cpu import stack4_pkg::*; #(
  parameter int STACK_DEPTH = 8,
  parameter logic [AW-1:0] RSV_BASE = 12'hFE2,
  localparam int CW = $clog2(STACK_DEPTH + 1),
  localparam int RET_NIB = AW / DW,
  localparam int RSV_SLOTS = ((1 << AW) - int'(RSV_BASE)) / RET_NIB,
  localparam int KW = $clog2(RSV_SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] tos_o,
  output logic [CW-1:0] depth_o,
  output logic          carry_o,
  output logic          err_o
);
  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OPND, S_EXEC, S_LDW, S_CALL, S_RET, S_HALT} st_e;

  st_e           st_q;
  op_e           ir_q;
  logic [AW-1:0] pc_q, opnd_q, rp_q, kx;
  logic [1:0]    cnt_q, k_q;
  logic [KW-1:0] calls_q;
  logic          carry_q, err_q;

  sk_op_e        sk_op;
  logic [DW-1:0] sk_data, tos, nos, alu_y, ret_nib;
  logic [CW-1:0] depth;
  logic          alu_c, grow, fault;
  logic [1:0]    need;

  stack4_opstack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_ni, .op_i(sk_op), .data_i(sk_data), .tos_o(tos), .nos_o(nos), .depth_o(depth)
  );

  stack4_alu u_alu (.op_i(ir_q), .a_i(nos), .b_i(tos), .y_o(alu_y), .c_o(alu_c));

  assign kx = {{(AW-2){1'b0}}, k_q};
  assign ret_nib = (k_q == 2'd0) ? pc_q[3:0] : (k_q == 2'd1) ? pc_q[7:4] : pc_q[11:8];

  always_comb begin
    need = 2'd0;
    grow = 1'b0;
    case (ir_q)
      OP_PUSH, OP_LOAD: grow = 1'b1;
      OP_DUP: begin need = 2'd1; grow = 1'b1; end
      OP_STORE, OP_JZ, OP_NOT, OP_DROP: need = 2'd1;
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SWAP: need = 2'd2;
      default: ;
    endcase
    fault = (CW'(need) > depth) || (grow && depth == CW'(STACK_DEPTH)) ||
            (ir_q == OP_CALL && calls_q == KW'(RSV_SLOTS)) ||
            (ir_q == OP_RET && calls_q == '0);
  end

  always_comb begin
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    sk_op       = SK_NONE;
    sk_data     = alu_y;
    case (st_q)
      S_EXEC: if (!fault) begin
        case (ir_q)
          OP_PUSH: begin sk_op = SK_PUSH; sk_data = opnd_q[AW-1 -: DW]; end
          OP_LOAD: mem_addr_o = opnd_q;
          OP_STORE: begin
            mem_addr_o  = opnd_q;
            mem_we_o    = (opnd_q < RSV_BASE);
            mem_wdata_o = tos;
            sk_op       = SK_POP;
          end
          OP_JZ, OP_DROP: sk_op = SK_POP;
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: sk_op = SK_BIN;
          OP_NOT: sk_op = SK_REPL;
          OP_DUP: begin sk_op = SK_PUSH; sk_data = tos; end
          OP_SWAP: sk_op = SK_SWAP;
          OP_RET: mem_addr_o = rp_q - AW'(1);
          default: ;
        endcase
      end
      S_LDW: begin sk_op = SK_PUSH; sk_data = mem_rdata_i; end
      S_CALL: begin mem_addr_o = rp_q + kx; mem_we_o = 1'b1; mem_wdata_o = ret_nib; end
      S_RET: mem_addr_o = rp_q - AW'(2) - kx;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_FETCH; ir_q <= OP_PUSH; pc_q <= '0; opnd_q <= '0; rp_q <= RSV_BASE;
      cnt_q <= '0; k_q <= '0; calls_q <= '0; carry_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st_q)
        S_FETCH: begin pc_q <= pc_q + AW'(1); st_q <= S_DEC; end
        S_DEC: begin
          ir_q  <= op_e'(mem_rdata_i);
          cnt_q <= op_len(op_e'(mem_rdata_i));
          if (op_len(op_e'(mem_rdata_i)) != 2'd0) begin
            pc_q <= pc_q + AW'(1);
            st_q <= S_OPND;
          end else st_q <= S_EXEC;
        end
        S_OPND: begin
          opnd_q <= {mem_rdata_i, opnd_q[AW-1:DW]};
          cnt_q  <= cnt_q - 2'd1;
          if (cnt_q != 2'd1) pc_q <= pc_q + AW'(1);
          else st_q <= S_EXEC;
        end
        S_EXEC: begin
          if (fault) begin
            err_q <= 1'b1;
            st_q  <= S_HALT;
          end else begin
            st_q <= S_FETCH;
            k_q  <= '0;
            case (ir_q)
              OP_LOAD: st_q <= S_LDW;
              OP_JMP:  pc_q <= opnd_q;
              OP_JZ:   if (tos == '0) pc_q <= opnd_q;
              OP_CALL: st_q <= S_CALL;
              OP_RET:  st_q <= S_RET;
              OP_ADD, OP_SUB: carry_q <= alu_c;
              default: ;
            endcase
          end
        end
        S_LDW: st_q <= S_FETCH;
        S_CALL: begin
          k_q <= k_q + 2'd1;
          if (k_q == 2'(RET_NIB - 1)) begin
            pc_q    <= opnd_q;
            rp_q    <= rp_q + AW'(RET_NIB);
            calls_q <= calls_q + KW'(1);
            st_q    <= S_FETCH;
          end
        end
        S_RET: begin
          // most significant nibble arrives first
          opnd_q <= {opnd_q[AW-DW-1:0], mem_rdata_i};
          k_q    <= k_q + 2'd1;
          if (k_q == 2'(RET_NIB - 1)) begin
            pc_q    <= {opnd_q[AW-DW-1:0], mem_rdata_i};
            rp_q    <= rp_q - AW'(RET_NIB);
            calls_q <= calls_q - KW'(1);
            st_q    <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  assign tos_o   = tos;
  assign depth_o = depth;
  assign carry_o = carry_q;
  assign err_o   = err_q;

  // R5
  rsv_call_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o >= RSV_BASE) |-> ir_q == OP_CALL);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!mem_we_o && $stable(depth_o) && $stable(tos_o)));
  // R3
  carry_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carry_o) |-> $past(st_q == S_EXEC && (ir_q == OP_ADD || ir_q == OP_SUB)));
endmodule

// File: tb/tb_stack4_cpu.sv
`timescale 1ns/1ps
module tb_stack4_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr;
  logic        we;
  logic [3:0]  wdata, rdata, tos;
  logic [3:0]  depth;
  logic        carry, err;

  logic [3:0]  img [4096];
  logic [3:0]  mem [4096];
  int          checks = 0, errors = 0, pp = 0, halt_wr = 0;

  always #4 clk = ~clk;

  stack4_cpu dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_we_o(we), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .tos_o(tos), .depth_o(depth), .carry_o(carry), .err_o(err)
  );

  always @(posedge clk) begin
    if (!rst_n) mem <= img;
    else if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  always @(negedge clk) if (rst_n && err && we) halt_wr++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 4096; i++) img[i] = 4'h0;
    pp = 0;
  endtask

  task automatic emit(input logic [3:0] n);
    img[pp] = n;
    pp++;
  endtask

  task automatic emit_a(input logic [3:0] op, input logic [11:0] a);
    emit(op); emit(a[3:0]); emit(a[7:4]); emit(a[11:8]);
  endtask

  task automatic stop();
    emit_a(4'h3, 12'(pp));
  endtask

  task automatic run(input int n);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [4:0] ref_alu(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
    case (op)
      4'h7: return {1'b0, a} + {1'b0, b};
      4'h8: return {(a < b), 4'(a - b)};
      4'h9: return {1'b0, a & b};
      4'hA: return {1'b0, a | b};
      default: return {1'b0, a ^ b};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2917));
    // R1 reset state
    clear(); stop();
    repeat (2) @(negedge clk);
    chk("R1 depth", 16'(depth), 0); chk("R1 err", 16'(err), 0);
    chk("R1 carry", 16'(carry), 0); chk("R1 we", 16'(we), 0);
    chk("R1 tos", 16'(tos), 0); chk("R1 addr", addr, 0);

    // R2 LOAD with little-endian address
    clear(); img[12'h234] = 4'h9; emit_a(4'h1, 12'h234); stop();
    run(100);
    chk("R2 load tos", 16'(tos), 9); chk("R2 load depth", 16'(depth), 1);

    // R3 random binary ops
    for (int t = 0; t < 24; t++) begin
      logic [3:0] a, b, op;
      logic [4:0] e;
      a = 4'($urandom_range(15)); b = 4'($urandom_range(15));
      op = 4'(7 + $urandom_range(4));
      if (t == 0) begin a = 4'hF; b = 4'h1; op = 4'h7; end
      if (t == 1) begin a = 4'h2; b = 4'h3; op = 4'h8; end
      if (t == 2) begin a = 4'h5; b = 4'h5; op = 4'h8; end
      clear(); emit(0); emit(a); emit(0); emit(b); emit(op); emit_a(4'h2, 12'h100); stop();
      run(120);
      e = ref_alu(op, a, b);
      chk("R3 result", 16'(mem[12'h100]), 16'(e[3:0]));
      chk("R3 carry", 16'(carry), 16'(e[4]));
    end

    // R3 carry held across AND
    clear(); emit(0); emit(4'hF); emit(0); emit(1); emit(4'h7); emit(0); emit(3); emit(4'h9); stop();
    run(150);
    chk("R3 carry kept", 16'(carry), 1); chk("R3 and tos", 16'(tos), 0); chk("R3 depth", 16'(depth), 1);

    // R4 SWAP NOT DUP DROP
    clear(); emit(0); emit(3); emit(0); emit(5); emit(4'hF);
    emit_a(4'h2, 12'h300); emit_a(4'h2, 12'h301);
    emit(0); emit(6); emit(4'hC); emit(4'hD); emit(0); emit(1); emit(4'hE); stop();
    run(250);
    chk("R4 swap top", 16'(mem[12'h300]), 3); chk("R4 swap second", 16'(mem[12'h301]), 5);
    chk("R4 not/dup tos", 16'(tos), 9); chk("R4 depth", 16'(depth), 2);

    // R5 store into and below the return window
    clear(); img[12'hFE5] = 4'hA;
    emit(0); emit(5); emit_a(4'h2, 12'hFE5); emit(0); emit(6); emit_a(4'h2, 12'hFE1); stop();
    run(150);
    chk("R5 blocked", 16'(mem[12'hFE5]), 16'hA); chk("R5 written", 16'(mem[12'hFE1]), 6);
    chk("R5 popped", 16'(depth), 0); chk("R5 no err", 16'(err), 0);

    // R6 JZ taken and not taken
    for (int v = 0; v < 2; v++) begin
      clear(); emit(0); emit(v ? 4'h7 : 4'h0); emit_a(4'h4, 12'h040);
      emit(0); emit(2); emit_a(4'h2, 12'h300); stop();
      pp = 12'h040; emit(0); emit(1); emit_a(4'h2, 12'h300); stop();
      run(150);
      chk("R6 jz path", 16'(mem[12'h300]), v ? 2 : 1); chk("R6 jz pop", 16'(depth), 0);
    end

    // R7 call and return
    clear(); emit_a(4'h3, 12'h123);
    pp = 12'h123; emit_a(4'h5, 12'h456); emit(0); emit(7); emit_a(4'h2, 12'h300); stop();
    pp = 12'h456; emit(0); emit(3); emit_a(4'h2, 12'h301); emit(4'h6);
    run(250);
    chk("R7 ret slot0", 16'(mem[12'hFE2]), 7); chk("R7 ret slot1", 16'(mem[12'hFE3]), 2);
    chk("R7 ret slot2", 16'(mem[12'hFE4]), 1); chk("R7 sub ran", 16'(mem[12'h301]), 3);
    chk("R7 returned", 16'(mem[12'h300]), 7); chk("R7 no err", 16'(err), 0);

    // R8 overflow halts before the store
    clear(); img[12'h300] = 4'hC;
    for (int i = 0; i < 9; i++) begin emit(0); emit(4'(i)); end
    emit_a(4'h2, 12'h300); stop();
    run(250);
    chk("R8 ovf err", 16'(err), 1); chk("R8 ovf depth", 16'(depth), 8);
    chk("R8 ovf tos", 16'(tos), 7); chk("R10 no store", 16'(mem[12'h300]), 16'hC);

    // R8 underflow
    clear(); emit(0); emit(4); emit(4'h7); stop();
    run(100);
    chk("R8 unf err", 16'(err), 1); chk("R8 unf depth", 16'(depth), 1); chk("R8 unf tos", 16'(tos), 4);

    // R9 window full by recursion, and RET with no call
    clear(); emit_a(4'h5, 12'h000);
    run(400);
    chk("R9 full err", 16'(err), 1); chk("R9 last slot", 16'(mem[12'hFFD]), 4);
    chk("R9 last slot hi", 16'(mem[12'hFFF]), 0);
    clear(); emit(4'h6); stop();
    run(80);
    chk("R9 ret empty err", 16'(err), 1);

    // R10 no write while halted, across all faulted runs
    chk("R10 halt writes", 16'(halt_wr), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule